// File: doc/BRIEF.md
# Mailbox Bus Takeover Controller

This block sits on the host side of a small processor system. It borrows the processor's memory bus to serve a command mailbox in the processor's RAM. The processor posts a command byte, a parameter byte and a payload of up to 128 bytes. It then halts on its ready line and pulls that line low while it waits. The controller sees the low level and holds the ready line low itself. It then withdraws the processor's bus enable and drives its own address lines, data lines and read/write strobes into the shared RAM.

The controller reads the command, the parameter and the payload. The parameter gives the payload length, limited to 128 bytes. Payload bytes are handed to a local executor as they arrive, and the executor is then told to start. When the executor reports completion, the controller writes its result bytes into the payload area and writes the return code last. It then hands the bus back in a fixed order: its drivers go off, bus enable rises, the ready line is released, and an interrupt pulse wakes the processor.

Mailbox layout (byte addresses): payload at PAY_BASE upward (default 0x00..0x7F), command at 0x80, parameter at 0x81, return code at 0x82.

Top module: `mbox_bus_master`

## Requirements
- R1: After reset, be_o=1, rdy_low_o=0, bus_oe_o=0, rd_o=0, wr_o=0 and irq_o=0.
- R2: When idle and rdy_i is sampled low, rdy_low_o goes to 1 in the next cycle while be_o stays 1. One cycle later be_o goes to 0 with bus_oe_o still 0. One cycle after that bus_oe_o goes to 1.
- R3: bus_oe_o is 1 only while be_o=0 and rdy_low_o=1.
- R4: Reads happen in this order: the command at 0x80, the parameter at 0x81, then payload bytes at PAY_BASE+i for i counting up from 0. The payload length is min(parameter, PAY_MAX), and a length of 0 means no payload reads.
- R5: Each rd_o or wr_o pulse stays high for exactly STROBE_CYC cycles, with addr_o stable while it is high. rd_o and wr_o are never high together, and neither is high outside bus_oe_o.
- R6: Each payload byte appears on pay_data_o with pay_valid_o=1 and pay_idx_o equal to its index. After the last read, exec_start_o pulses for exactly one cycle, with exec_cmd_o and exec_param_o holding the bytes read.
- R7: After exec_done_i, the controller writes min(res_len_i, PAY_MAX) bytes to PAY_BASE+i, each taken from res_data_i while res_idx_o=i. It then writes ret_code_i to 0x82 as the last write. Payload bytes above the result length are left unchanged.
- R8: Release goes in one-cycle steps: bus_oe_o falls, be_o rises, rdy_low_o falls, and irq_o rises. irq_o stays high for exactly IRQ_CYC cycles and only while be_o=1 and rdy_low_o=0.
- R9: A new request is not taken until irq_o has ended and rdy_i has been sampled high. If rdy_i stays low across the interrupt, the bus stays with the processor.
- R10: data_oe_o is high during every write strobe and never during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Sensed level of the processor ready line |
| rdy_low_o | output | 1 | 1 = controller pulls the ready line low |
| be_o | output | 1 | Processor bus enable (0 = processor bus tri-stated) |
| bus_oe_o | output | 1 | Enable for the controller's address and strobe drivers |
| addr_o | output | ADDR_W | Shared memory address |
| data_i | input | DATA_W | Read data from shared memory |
| data_o | output | DATA_W | Write data to shared memory |
| data_oe_o | output | 1 | Enable for the controller's data drivers |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| irq_o | output | 1 | Wake-up interrupt pulse to the processor |
| pay_valid_o | output | 1 | Payload byte valid |
| pay_idx_o | output | IDX_W | Payload byte index |
| pay_data_o | output | DATA_W | Payload byte |
| exec_start_o | output | 1 | One-cycle start to the executor |
| exec_cmd_o | output | DATA_W | Command byte |
| exec_param_o | output | DATA_W | Parameter byte |
| exec_done_i | input | 1 | Executor finished |
| res_len_i | input | DATA_W | Result length in bytes, sampled with exec_done_i |
| ret_code_i | input | DATA_W | Return code, sampled with exec_done_i |
| res_idx_o | output | IDX_W | Index of the result byte being requested |
| res_data_i | input | DATA_W | Result byte at res_idx_o |

## Verification
The checks assume that rdy_i falls only when the processor is parked waiting. They also assume the executor raises exec_done_i no earlier than the cycle after exec_start_o, and that res_data_i depends only on res_idx_o. The bench models the ready line as a wired-low of the processor's pull and rdy_low_o, so the line cannot float high while the controller holds it. Its executor model answers after a delay of at least one cycle and computes result bytes as a pure function of the index. Random transactions draw the command, the lengths (including values above 128) and the return code. Directed cases cover zero lengths, full lengths and a ready line held low across the wake-up interrupt.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_GRAB, S_PARK, S_RD_CMD, S_RD_PAR, S_RD_PAY, S_EXEC,
    S_WR_PAY, S_WR_RET, S_UNDRIVE, S_BE_UP, S_RDY_OFF, S_IRQ
  } seq_state_e;

  typedef enum logic [1:0] {E_IDLE, E_STB, E_GAP} eng_state_e;
endpackage

// File: rtl/mbox_access_engine.sv
module mbox_access_engine
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              data_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  eng_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (go_i) begin
          st_q    <= E_STB;
          cnt_q   <= CNT_W'(STROBE_CYC - 1);
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        E_STB: if (cnt_q == '0) begin
          st_q <= E_GAP;
          if (!we_q) rdata_q <= data_i;  // sample at end of strobe
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign addr_o    = addr_q;
  assign data_o    = wdata_q;
  assign rd_o      = (st_q == E_STB) && !we_q;
  assign wr_o      = (st_q == E_STB) && we_q;
  assign data_oe_o = (st_q != E_IDLE) && we_q;  // hold data through gap
  assign done_o    = (st_q == E_GAP);
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mbox_irq_pulse.sv
module mbox_irq_pulse #(
  parameter int IRQ_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic irq_o
);
  localparam int CNT_W = $clog2(IRQ_CYC + 1);

  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !irq_q) begin
      irq_q <= 1'b1;
      cnt_q <= CNT_W'(IRQ_CYC - 1);
    end else if (irq_q) begin
      if (cnt_q == '0) irq_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mbox_bus_master.sv
module mbox_bus_master
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAY_MAX    = 128,
  parameter int PAY_BASE   = 0,
  parameter int CMD_ADDR   = 128,
  parameter int PARAM_ADDR = 129,
  parameter int RET_ADDR   = 130,
  parameter int STROBE_CYC = 2,
  parameter int IRQ_CYC    = 4,
  localparam int IDX_W     = $clog2(PAY_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rdy_i,
  output logic              rdy_low_o,
  output logic              be_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              irq_o,
  output logic              pay_valid_o,
  output logic [IDX_W-1:0]  pay_idx_o,
  output logic [DATA_W-1:0] pay_data_o,
  output logic              exec_start_o,
  output logic [DATA_W-1:0] exec_cmd_o,
  output logic [DATA_W-1:0] exec_param_o,
  input  logic              exec_done_i,
  input  logic [DATA_W-1:0] res_len_i,
  input  logic [DATA_W-1:0] ret_code_i,
  output logic [IDX_W-1:0]  res_idx_o,
  input  logic [DATA_W-1:0] res_data_i
);
  function automatic logic [IDX_W-1:0] clamp_len(input logic [DATA_W-1:0] v);
    if (int'(v) > PAY_MAX) return IDX_W'(PAY_MAX);
    return IDX_W'(v);
  endfunction

  seq_state_e        st_q;
  logic [IDX_W-1:0]  idx_q, len_q;
  logic [DATA_W-1:0] cmd_q, par_q, ret_q;
  logic              start_q;

  logic              acc_go, acc_we, acc_done;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, acc_rdata;
  logic [IDX_W-1:0]  rd_len, wr_len;

  assign rd_len = clamp_len(acc_rdata);
  assign wr_len = clamp_len(res_len_i);

  always_comb begin
    acc_go    = 1'b0;
    acc_we    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    case (st_q)
      S_RD_CMD: begin acc_go = 1'b1; acc_addr = ADDR_W'(CMD_ADDR); end
      S_RD_PAR: begin acc_go = 1'b1; acc_addr = ADDR_W'(PARAM_ADDR); end
      S_RD_PAY: begin acc_go = 1'b1; acc_addr = ADDR_W'(PAY_BASE) + ADDR_W'(idx_q); end
      S_WR_PAY: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = ADDR_W'(PAY_BASE) + ADDR_W'(idx_q);
        acc_wdata = res_data_i;
      end
      S_WR_RET: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = ADDR_W'(RET_ADDR); acc_wdata = ret_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
      par_q   <= '0;
      ret_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        S_IDLE:   if (!rdy_i) st_q <= S_GRAB;
        S_GRAB:   st_q <= S_PARK;
        S_PARK:   st_q <= S_RD_CMD;
        S_RD_CMD: if (acc_done) begin cmd_q <= acc_rdata; st_q <= S_RD_PAR; end
        S_RD_PAR: if (acc_done) begin
          par_q <= acc_rdata;
          len_q <= rd_len;
          idx_q <= '0;
          if (rd_len == '0) begin st_q <= S_EXEC; start_q <= 1'b1; end
          else st_q <= S_RD_PAY;
        end
        S_RD_PAY: if (acc_done) begin
          if (idx_q == len_q - 1'b1) begin st_q <= S_EXEC; start_q <= 1'b1; end
          else idx_q <= idx_q + 1'b1;
        end
        S_EXEC: if (exec_done_i && !start_q) begin
          ret_q <= ret_code_i;
          len_q <= wr_len;
          idx_q <= '0;
          st_q  <= (wr_len == '0) ? S_WR_RET : S_WR_PAY;
        end
        S_WR_PAY: if (acc_done) begin
          if (idx_q == len_q - 1'b1) st_q <= S_WR_RET;
          else idx_q <= idx_q + 1'b1;
        end
        S_WR_RET:  if (acc_done) st_q <= S_UNDRIVE;  // return code is the last write
        S_UNDRIVE: st_q <= S_BE_UP;
        S_BE_UP:   st_q <= S_RDY_OFF;
        S_RDY_OFF: st_q <= S_IRQ;
        S_IRQ:     if (!irq_o && rdy_i) st_q <= S_IDLE;  // rearm only after ready seen high
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  mbox_access_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
  ) u_eng (
    .clk_i, .rst_ni,
    .go_i(acc_go), .we_i(acc_we), .addr_i(acc_addr), .wdata_i(acc_wdata),
    .data_i, .addr_o, .data_o, .rd_o, .wr_o, .data_oe_o,
    .done_o(acc_done), .rdata_o(acc_rdata)
  );

  mbox_irq_pulse #(.IRQ_CYC(IRQ_CYC)) u_irq (
    .clk_i, .rst_ni, .start_i(st_q == S_RDY_OFF), .irq_o
  );

  assign rdy_low_o    = st_q inside {S_GRAB, S_PARK, S_RD_CMD, S_RD_PAR, S_RD_PAY,
                                     S_EXEC, S_WR_PAY, S_WR_RET, S_UNDRIVE, S_BE_UP};
  assign be_o         = !(st_q inside {S_PARK, S_RD_CMD, S_RD_PAR, S_RD_PAY,
                                       S_EXEC, S_WR_PAY, S_WR_RET, S_UNDRIVE});
  assign bus_oe_o     = st_q inside {S_RD_CMD, S_RD_PAR, S_RD_PAY, S_EXEC,
                                     S_WR_PAY, S_WR_RET};
  assign pay_valid_o  = (st_q == S_RD_PAY) && acc_done;
  assign pay_idx_o    = idx_q;
  assign pay_data_o   = acc_rdata;
  assign exec_start_o = start_q;
  assign exec_cmd_o   = cmd_q;
  assign exec_param_o = par_q;
  assign res_idx_o    = idx_q;
endmodule

// File: rtl/mbox_bus_master_chk.sv
module mbox_bus_master_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              be_o,
  input logic              rdy_low_o,
  input logic              bus_oe_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              data_oe_o,
  input logic              irq_o,
  input logic              exec_start_o,
  input logic [ADDR_W-1:0] addr_o
);
  // R2
  be_drop_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(be_o) |-> $past(rdy_low_o));
  // R3
  oe_when_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!be_o && rdy_low_o));
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  // R5
  strobe_in_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> bus_oe_o);
  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && $past(rd_o || wr_o)) |-> $stable(addr_o));
  // R6
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);
  // R8
  be_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(be_o) |-> !$past(bus_oe_o));
  // R8
  irq_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (be_o && !rdy_low_o));
  // R10
  data_oe_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !data_oe_o);
  // R10
  data_oe_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> data_oe_o);
endmodule

bind mbox_bus_master mbox_bus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .be_o(be_o), .rdy_low_o(rdy_low_o),
  .bus_oe_o(bus_oe_o), .rd_o(rd_o), .wr_o(wr_o), .data_oe_o(data_oe_o),
  .irq_o(irq_o), .exec_start_o(exec_start_o), .addr_o(addr_o)
);

// File: tb/mbox_bus_master_test.sv
module mbox_bus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int STB = 2;
  localparam int IRQW = 4;
  localparam int PMAX = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cpu_pull = 1'b0;
  logic       rdy_i, rdy_low_o, be_o, bus_oe_o, data_oe_o, rd_o, wr_o, irq_o;
  logic [7:0] addr_o, data_i, data_o;
  logic       pay_valid_o, exec_start_o, exec_done_i = 1'b0;
  logic [7:0] pay_idx_o, pay_data_o, exec_cmd_o, exec_param_o;
  logic [7:0] res_len_i = 8'd0, ret_code_i = 8'd0, res_idx_o, res_data_i;
  logic [7:0] res_key = 8'd0;
  logic [7:0] mem [256];
  logic [7:0] snap [256];

  function automatic logic [7:0] resf(input logic [7:0] i, input logic [7:0] k);
    return 8'(i * 8'd37) ^ k;
  endfunction
  function automatic int clampv(input int v);
    return (v > PMAX) ? PMAX : v;
  endfunction

  assign rdy_i      = !(cpu_pull || rdy_low_o);
  assign data_i     = mem[addr_o];
  assign res_data_i = resf(res_idx_o, res_key);

  mbox_bus_master #(.STROBE_CYC(STB), .IRQ_CYC(IRQW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rdy_i, .rdy_low_o, .be_o, .bus_oe_o,
    .addr_o, .data_i, .data_o, .data_oe_o, .rd_o, .wr_o, .irq_o,
    .pay_valid_o, .pay_idx_o, .pay_data_o, .exec_start_o, .exec_cmd_o,
    .exec_param_o, .exec_done_i, .res_len_i, .ret_code_i, .res_idx_o, .res_data_i
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  int   cyc = 0, log_n = 0, pay_n = 0, pay_idx_err = 0;
  logic lg_we [400];
  logic [7:0] lg_addr [400], lg_data [400], pay_got [200];
  int   run = 0, stb_err = 0, oe_err = 0, doe_err = 0;
  int   t_oe = 0, t_be = 0, t_rl = 0, t_ir = 0, irq_run = 0, irq_w = 0;
  int   ex_cnt = 0, ex_delay = 1, ex_seen = 0;
  logic [7:0] ex_cmd = 0, ex_par = 0;
  logic p_rw = 0, p_oe = 0, p_be = 1, p_rl = 0, p_irq = 0;

  always @(negedge clk) begin
    cyc++;
    if (wr_o) mem[addr_o] = data_o;
    if ((rd_o || wr_o) && !p_rw && log_n < 400) begin
      lg_we[log_n] = wr_o; lg_addr[log_n] = addr_o; lg_data[log_n] = data_o; log_n++;
    end
    if (rd_o || wr_o) run++;
    else if (run != 0) begin if (run != STB) stb_err++; run = 0; end
    if (bus_oe_o && (be_o || !rdy_low_o)) oe_err++;
    if ((data_oe_o && rd_o) || (wr_o && !data_oe_o)) doe_err++;
    if (p_oe && !bus_oe_o) t_oe = cyc;
    if (!p_be && be_o) t_be = cyc;
    if (p_rl && !rdy_low_o) t_rl = cyc;
    if (!p_irq && irq_o) t_ir = cyc;
    if (irq_o) irq_run++;
    else if (p_irq) begin irq_w = irq_run; irq_run = 0; end
    if (pay_valid_o && pay_n < 200) begin
      if (int'(pay_idx_o) != pay_n) pay_idx_err++;
      pay_got[pay_n] = pay_data_o; pay_n++;
    end
    exec_done_i = 1'b0;
    if (ex_cnt > 0) begin ex_cnt--; if (ex_cnt == 0) exec_done_i = 1'b1; end
    if (exec_start_o) begin
      ex_cmd = exec_cmd_o; ex_par = exec_param_o; ex_seen++; ex_cnt = ex_delay;
    end
    p_rw = rd_o || wr_o; p_oe = bus_oe_o; p_be = be_o; p_rl = rdy_low_o; p_irq = irq_o;
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_txn(input logic [7:0] cmd, input logic [7:0] par,
                         input logic [7:0] rl, input logic [7:0] rc,
                         input int dly, input bit hold);
    int lin, lout, n, exp_n, mism;
    bit ok;
    lin = clampv(int'(par)); lout = clampv(int'(rl));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[128] = cmd; mem[129] = par;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    res_len_i = rl; ret_code_i = rc; ex_delay = dly; res_key = 8'($urandom);
    log_n = 0; pay_n = 0; pay_idx_err = 0; stb_err = 0; oe_err = 0; doe_err = 0;
    t_oe = 0; t_be = 0; t_rl = 0; t_ir = 0; irq_w = 0; ex_seen = 0;
    @(negedge clk) cpu_pull = 1'b1;
    // R2 grab sequence
    @(negedge clk) ok = rdy_low_o && be_o && !bus_oe_o;
    @(negedge clk) ok = ok && rdy_low_o && !be_o && !bus_oe_o;
    @(negedge clk) ok = ok && bus_oe_o;
    chk(ok, "R2 grab order", int'(ok), 1);
    n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R8 irq reached", n, 0);
    if (!hold) cpu_pull = 1'b0;
    n = 0;
    while (irq_o && n < 100) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);

    exp_n = 3 + lin + lout;
    chk(log_n == exp_n, "R4/R7 access count", log_n, exp_n);
    mism = 0;
    if (log_n == exp_n) begin
      if (lg_we[0] || lg_addr[0] != 8'h80) mism++;
      if (lg_we[1] || lg_addr[1] != 8'h81) mism++;
      for (int i = 0; i < lin; i++) if (lg_we[2+i] || int'(lg_addr[2+i]) != i) mism++;
    end
    chk(mism == 0, "R4 read order", mism, 0);
    mism = 0;
    if (log_n == exp_n) begin
      for (int i = 0; i < lout; i++)
        if (!lg_we[2+lin+i] || int'(lg_addr[2+lin+i]) != i ||
            lg_data[2+lin+i] != resf(8'(i), res_key)) mism++;
    end
    chk(mism == 0, "R7 result writes", mism, 0);
    chk(log_n > 0 && lg_we[log_n-1] && lg_addr[log_n-1] == 8'h82 && lg_data[log_n-1] == rc,
        "R7 return code last", int'(lg_data[log_n > 0 ? log_n-1 : 0]), int'(rc));
    mism = 0;
    for (int i = 0; i < PMAX; i++)
      if (mem[i] != ((i < lout) ? resf(8'(i), res_key) : snap[i])) mism++;
    chk(mism == 0 && mem[130] == rc, "R7 memory image", mism, 0);
    mism = pay_idx_err;
    if (pay_n != lin) mism++;
    else for (int i = 0; i < lin; i++) if (pay_got[i] != snap[i]) mism++;
    chk(mism == 0, "R6 payload stream", pay_n, lin);
    chk(ex_seen == 1 && ex_cmd == cmd && ex_par == par, "R6 exec cmd/param",
        int'(ex_cmd), int'(cmd));
    chk(t_be - t_oe == 1 && t_rl - t_be == 1 && t_ir - t_rl == 1, "R8 release steps",
        t_ir - t_oe, 3);
    chk(irq_w == IRQW, "R8 irq width", irq_w, IRQW);
    chk(stb_err == 0, "R5 strobe width", stb_err, 0);
    chk(oe_err == 0, "R3 drive only when owned", oe_err, 0);
    chk(doe_err == 0, "R10 data enable", doe_err, 0);
  endtask

  initial begin
    void'($urandom(32'd20190129));
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(be_o && !rdy_low_o && !bus_oe_o && !rd_o && !wr_o && !irq_o, "R1 reset state",
        int'({be_o, rdy_low_o, bus_oe_o, rd_o, wr_o, irq_o}), 32);

    run_txn(8'h11, 8'd0,   8'd0,   8'h5A, 1, 1'b0);  // empty both ways
    run_txn(8'h22, 8'd128, 8'd128, 8'hA5, 3, 1'b0);  // full both ways
    run_txn(8'h33, 8'd200, 8'd255, 8'h01, 2, 1'b0);  // clamp to 128
    run_txn(8'h44, 8'd1,   8'd1,   8'hFF, 1, 1'b0);
    run_txn(8'h55, 8'd127, 8'd3,   8'h00, 5, 1'b0);

    // R9: ready held low across the interrupt must not rearm
    run_txn(8'h66, 8'd4, 8'd2, 8'h7E, 2, 1'b1);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (rdy_low_o || !be_o) ok = 1'b0;
      end
      chk(ok, "R9 no rearm while ready low", int'(ok), 1);
    end
    cpu_pull = 1'b0;
    run_txn(8'h77, 8'd5, 8'd6, 8'h3C, 1, 1'b0);  // R9 rearm after high

    for (int k = 0; k < 8; k++)
      run_txn(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              1 + int'($urandom % 6), 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule